// File: doc/BRIEF.md
# Instruction Cache Tag Invalidation Sequencer

This block drives the write port of a 64-line direct-mapped instruction cache tag array whenever entries have to be made invalid. It accepts two kinds of request. A write of the invalidate-all control bit starts a timed walk: one tag location is cleared per cycle, from index 0 up to index 63, and instruction fetches are held off for the whole walk. A privileged single-line request carries a source address and clears only the entry that address selects. The single-line request is honoured only while the push-invalidate disable control bit is clear.

The tag array, the data array, hit detection and instruction decoding are outside the block. It only produces the tag write strobe, the write index and the valid value to write, which is always 0. It also drives a fetch-stall level and a one-cycle done pulse when a walk finishes. The invalidate-all bit clears itself at the end of the walk. Reset puts the block idle but does not write any tag entry.

Top module: `tagInvSeq`

## Requirements
- R1: During and after reset, with no request given, `tagWrEn`, `fetchStall` and `walkDone` are 0, so reset writes no tag entry.
- R2: A pulse on `invAllSet` while idle starts a walk in the next cycle. The walk lasts exactly 64 consecutive cycles, with `tagWrEn`=1 and `tagWrIdx` going 0, 1, ..., 63, one index per cycle.
- R3: `fetchStall` is 1 in exactly the cycles of a walk and 0 otherwise.
- R4: `walkDone` is 1 for exactly one cycle, the cycle right after the write of index 63. This is also the cycle in which `fetchStall` has returned to 0, because the invalidate-all bit has cleared itself.
- R5: A `lineReq` pulse while idle, with `pushDisable`=0, causes exactly one tag write in the next cycle, at index `lineAddr[9:4]`.
- R6: A `lineReq` while `pushDisable`=1 causes no tag write.
- R7: A `lineReq` given during a walk is absorbed. It adds no write and does not change the order of the walk.
- R8: An `invAllSet` given during a walk is ignored. The walk neither restarts nor grows longer.
- R9: `tagWrValid` is 0 in every cycle in which `tagWrEn` is 1.
- R10: When `invAllSet` and `lineReq` arrive in the same cycle while idle, only the walk happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| invAllSet | input | 1 | Write of the invalidate-all control bit (one-cycle pulse) |
| pushDisable | input | 1 | Control bit; when 1, single-line requests are refused |
| lineReq | input | 1 | Single-line invalidate request (one-cycle pulse) |
| lineAddr | input | 32 | Source address of the single-line request |
| tagWrEn | output | 1 | Tag array write strobe |
| tagWrIdx | output | 6 | Tag array write index |
| tagWrValid | output | 1 | Valid value written into the tag entry (always 0) |
| fetchStall | output | 1 | Holds off instruction fetches while a walk runs |
| walkDone | output | 1 | One-cycle pulse when a walk ends |

## Verification
The embedded assertions check the following in every cycle:
- the walk index advances by one per cycle with no gap;
- a stall always comes with a tag write;
- the done pulse is a single cycle and follows the end of a stall;
- the written valid bit is 0;
- a captured single-line request never coincides with a walk.

Only the bench scenarios can show the behaviours that need a count or a missing event:
- the walk covers all 64 indices and then stops;
- a refused or absorbed single-line request leaves no write behind;
- a second invalidate-all write does not lengthen the walk;
- a simultaneous request pair produces the walk alone.

// File: rtl/tagInvPkg.sv
package tagInvPkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic cntClear;   // load walk index with 0
    logic walkActive; // walk in progress: step index, drive it to the port
    logic lineCap;    // capture a single-line index for next cycle
  } ctlStrobes_t;
endpackage

// File: rtl/tagInvCtrl.sv
module tagInvCtrl
  import tagInvPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        invAllSet,
  input  logic        pushDisable,
  input  logic        lineReq,
  input  logic        cntLast,
  output ctlStrobes_t strb,
  output logic        walkDone
);
  logic walking;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walking  <= 1'b0;
      walkDone <= 1'b0;
    end else begin
      walkDone <= walking && cntLast;
      if (!walking && invAllSet)
        walking <= 1'b1;
      else if (walking && cntLast)
        walking <= 1'b0;
    end
  end

  always_comb begin
    strb.cntClear   = !walking && invAllSet;
    strb.walkActive = walking;
    // A walk clears every line anyway, so a line request is absorbed
    // during a walk or when it arrives together with a walk request.
    strb.lineCap    = !walking && !invAllSet && lineReq && !pushDisable;
  end

  // R4: the done pulse lasts one cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);
  // R4: done comes right after the walk has ended
  p_done_after_walk_r4: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |-> (!walking && $past(walking)));
  // R6: a refused request is never captured
  p_line_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    pushDisable |-> !strb.lineCap);
endmodule

// File: rtl/tagInvDp.sv
module tagInvDp
  import tagInvPkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int ADDR_W     = 32,
  parameter int OFFSET_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] lineAddr,
  output logic              cntLast,
  output logic              tagWrEn,
  output logic [IDX_W-1:0]  tagWrIdx,
  output logic              tagWrValid
);
  localparam int LINES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] walkIdx;
  logic [IDX_W-1:0] lineIdx;
  logic             linePend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkIdx  <= '0;
      lineIdx  <= '0;
      linePend <= 1'b0;
    end else begin
      if (strb.cntClear)
        walkIdx <= '0;
      else if (strb.walkActive)
        walkIdx <= walkIdx + 1'b1;
      linePend <= strb.lineCap;
      if (strb.lineCap)
        lineIdx <= lineAddr[OFFSET_LSB +: IDX_W];
    end
  end

  always_comb begin
    cntLast    = (walkIdx == LAST_IDX);
    tagWrEn    = strb.walkActive || linePend;
    tagWrIdx   = strb.walkActive ? walkIdx : lineIdx;
    tagWrValid = 1'b0;
  end

  // R2: consecutive walk cycles step the index by exactly one
  p_walk_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.walkActive && $past(strb.walkActive)) |->
      (tagWrIdx == $past(tagWrIdx) + 1'b1));
  // R2: a walk starts at index 0
  p_walk_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.walkActive) |-> (tagWrIdx == '0));
  // R7: a pending line write never overlaps a walk
  p_no_line_in_walk_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.walkActive |-> !linePend);
  // R9: a tag write always clears the valid bit
  p_valid_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    tagWrEn |-> !tagWrValid);
endmodule

// File: rtl/tagInvSeq.sv
module tagInvSeq
  import tagInvPkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int ADDR_W     = 32,
  parameter int OFFSET_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invAllSet,
  input  logic              pushDisable,
  input  logic              lineReq,
  input  logic [ADDR_W-1:0] lineAddr,
  output logic              tagWrEn,
  output logic [IDX_W-1:0]  tagWrIdx,
  output logic              tagWrValid,
  output logic              fetchStall,
  output logic              walkDone
);
  ctlStrobes_t strb;
  logic        cntLast;

  tagInvCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .invAllSet  (invAllSet),
    .pushDisable(pushDisable),
    .lineReq    (lineReq),
    .cntLast    (cntLast),
    .strb       (strb),
    .walkDone   (walkDone)
  );

  tagInvDp #(
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W),
    .OFFSET_LSB(OFFSET_LSB)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lineAddr  (lineAddr),
    .cntLast   (cntLast),
    .tagWrEn   (tagWrEn),
    .tagWrIdx  (tagWrIdx),
    .tagWrValid(tagWrValid)
  );

  assign fetchStall = strb.walkActive;

  // R3: fetches stall only while tags are being written
  p_stall_writes_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchStall |-> tagWrEn);
endmodule

// File: tb/tagInvSeq_tb.sv
module tagInvSeq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        invAllSet = 1'b0;
  logic        pushDisable = 1'b0;
  logic        lineReq = 1'b0;
  logic [31:0] lineAddr = '0;
  logic        tagWrEn;
  logic [5:0]  tagWrIdx;
  logic        tagWrValid;
  logic        fetchStall;
  logic        walkDone;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct packed {
    logic [5:0] idx;
    logic       stall;
  } expWr_t;
  expWr_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  tagInvSeq u_dut (
    .clk(clk), .rstN(rstN), .invAllSet(invAllSet), .pushDisable(pushDisable),
    .lineReq(lineReq), .lineAddr(lineAddr), .tagWrEn(tagWrEn),
    .tagWrIdx(tagWrIdx), .tagWrValid(tagWrValid), .fetchStall(fetchStall),
    .walkDone(walkDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares each tag write against the scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (tagWrEn) begin
        expWr_t e;
        if (expQ.size() == 0) begin
          check(1'b0, "R6/R7 unexpected write idx", int'(tagWrIdx), -1);
        end else begin
          e = expQ.pop_front();
          check(tagWrIdx == e.idx, "R2/R5 write index", int'(tagWrIdx), int'(e.idx));
          check(fetchStall == e.stall, "R3 stall during write", int'(fetchStall), int'(e.stall));
        end
        check(tagWrValid == 1'b0, "R9 valid written", int'(tagWrValid), 0);
      end else begin
        check(fetchStall == 1'b0, "R3 stall without walk", int'(fetchStall), 0);
      end
    end
  end

  task automatic pushWalk();
    for (int i = 0; i < 64; i++) expQ.push_back('{idx: 6'(i), stall: 1'b1});
  endtask

  // Waits from just after the start edge to the end of the walk and checks done
  task automatic finishWalk(input int cyclesUsed);
    repeat (64 - cyclesUsed) @(posedge clk);
    @(negedge clk);
    check(walkDone == 1'b1, "R4 done after last write", int'(walkDone), 1);
    check(fetchStall == 1'b0, "R4 invalidate bit self-cleared", int'(fetchStall), 0);
    @(negedge clk);
    check(walkDone == 1'b0, "R4 done single cycle", int'(walkDone), 0);
    check(expQ.size() == 0, "R2 all 64 entries written", expQ.size(), 0);
  endtask

  task automatic startWalk(input bit withLine);
    pushWalk();
    @(posedge clk); #1;
    invAllSet = 1'b1;
    lineReq = withLine;
    lineAddr = 32'h0000_0150;
    @(posedge clk); #1;
    invAllSet = 1'b0;
    lineReq = 1'b0;
  endtask

  task automatic lineInv(input logic [31:0] addr, input bit dis);
    if (!dis) expQ.push_back('{idx: addr[9:4], stall: 1'b0});
    @(posedge clk); #1;
    lineAddr = addr;
    pushDisable = dis;
    lineReq = 1'b1;
    @(posedge clk); #1;
    lineReq = 1'b0;
    @(negedge clk);
    check(tagWrEn == !dis, dis ? "R6 refused line" : "R5 line write", int'(tagWrEn), int'(!dis));
    @(negedge clk);
    check(tagWrEn == 1'b0, "R5 single write", int'(tagWrEn), 0);
    pushDisable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tagWrEn == 1'b0, "R1 no write in reset", int'(tagWrEn), 0);
    check(fetchStall == 1'b0, "R1 stall in reset", int'(fetchStall), 0);
    check(walkDone == 1'b0, "R1 done in reset", int'(walkDone), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(tagWrEn == 1'b0, "R1 no write after reset", int'(tagWrEn), 0);

    // R2/R3/R4 plain walk
    startWalk(1'b0);
    finishWalk(0);

    // R5 single lines, varied addresses
    lineInv(32'h0000_0000, 1'b0);
    lineInv(32'hFFFF_FFF0, 1'b0);
    lineInv(32'h1234_5AB7, 1'b0);
    // R6 refused when push-invalidate is disabled
    lineInv(32'h0000_0230, 1'b1);

    // R7 line request during a walk is absorbed
    startWalk(1'b0);
    repeat (10) @(posedge clk); #1;
    lineAddr = 32'h0000_03F0;
    lineReq = 1'b1;
    @(posedge clk); #1;
    lineReq = 1'b0;
    finishWalk(11);

    // R8 invalidate-all write during a walk is ignored
    startWalk(1'b0);
    repeat (20) @(posedge clk); #1;
    invAllSet = 1'b1;
    @(posedge clk); #1;
    invAllSet = 1'b0;
    finishWalk(21);
    repeat (3) @(negedge clk);
    check(tagWrEn == 1'b0, "R8 no restart", int'(tagWrEn), 0);

    // R10 simultaneous requests: walk only
    startWalk(1'b1);
    finishWalk(0);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10 no extra line write", expQ.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule